// File: doc/BRIEF.md
# Frame-Slot GPIO Control Unit

This block connects sixteen general-purpose pins to one 20-bit slot of a time-multiplexed audio link frame, on the codec side. At each frame strobe it does two things. It takes in the outbound slot word from the controller and updates the pins that are configured as outputs. It also latches a new inbound slot word, which carries the level of every pin and a sticky change-interrupt flag back to the controller.

Per-pin direction, output-enable and interrupt-mask settings come in as plain register vectors. Every pin powers up high-impedance. A pin's output buffer turns on only after the pin has received at least one value through the slot, so the controller sets the value first and enables the pin second. Input levels pass through a synchronizer. Changes on unmasked input pins are collected between frames. Each collection is reported exactly once, in bit 0 of the inbound slot.

Top module: `gpio_slot_ctl`

## Requirements
- R1: While reset is asserted and after it is released, `in_slot`, `pin_out` and `pin_oe` are all zero until the first frame strobe.
- R2: Pin i maps to slot bit 4+i. Inbound bits 3..1 are always zero. Outbound bits 3..0 have no effect on any output.
- R3: A pin with `cfg_dir` bit = 1 (output) drives the bit taken from the most recent outbound slot that was presented with `out_valid` high at a frame strobe. `pin_out` changes in the cycle after that strobe. A strobe with `out_valid` low changes nothing.
- R4: Outbound bits for pins with `cfg_dir` bit = 0 (input) are ignored, and those pins' `pin_out` bits keep their values.
- R5: `pin_oe[i]` is 1 only when `cfg_dir[i]`=1, `cfg_oe[i]`=1 and pin i has been written by a valid outbound slot while configured as output since reset.
- R6: In the inbound slot, an input pin reports its `pin_in` level, provided that level was stable for at least three clocks before the strobe. An output pin reports its driven value.
- R7: For output pins, the inbound slot latched at a strobe holds the values from before that strobe's outbound write.
- R8: A level change on an input pin whose `cfg_mask` bit is 1 sets bit 0 of the next inbound slot. Changes on masked-off pins or output pins do not set it.
- R9: Once the flag has been reported in one inbound slot, it reads 0 in the following slot unless a new qualifying change occurs.
- R10: `in_slot` changes only at frame strobes and holds its value between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| frame_strobe | input | 1 | One-cycle pulse at each frame's slot boundary |
| out_slot | input | 20 | Outbound slot word from the controller |
| out_valid | input | 1 | Outbound slot carries valid data this frame |
| in_slot | output | 20 | Inbound slot word, latched at the strobe |
| cfg_dir | input | 16 | Per-pin direction, 1 = output |
| cfg_oe | input | 16 | Per-pin output-buffer enable |
| cfg_mask | input | 16 | Per-pin change-interrupt enable, 1 = enabled |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output-buffer enables |

## Verification
The assertions check several properties on every cycle. `pin_out` moves only after a valid write. Input-configured pins never change at a strobe. `in_slot` holds between strobes, and its vendor bits stay zero. The output-pin status in each slot equals the pre-write value. Only the bench scenarios can show the cross-frame behaviour. That covers whether an input change reaches status and the flag after synchronization, whether the flag clears after exactly one report, and whether the load-before-enable ordering holds across direction changes. The bench covers these with per-pin walks and a long pseudo-random sweep over direction, mask, pin and slot patterns.

// File: rtl/gpio_slot_pkg.sv
package gpio_slot_pkg;
    localparam int unsigned SLOT_W    = 20;
    localparam int unsigned PIN_LSB   = 4;
    localparam int unsigned NPINS     = SLOT_W - PIN_LSB;
    localparam int unsigned VEND_W    = PIN_LSB - 1;
    localparam int unsigned IRQ_BIT   = 0;
    localparam int unsigned SYNC_STG  = 2;
endpackage

// File: rtl/gpio_slot_sync.sv
module gpio_slot_sync #(
    parameter int unsigned W      = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stage[s] = st_q.stage[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stage[STAGES-1];
endmodule

// File: rtl/gpio_slot_drv.sv
module gpio_slot_drv #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic         wr_valid_i,
    input  logic [W-1:0] wr_bits_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] oe_i,
    output logic [W-1:0] pin_out_o,
    output logic [W-1:0] pin_oe_o
);
    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] loaded;
    } drv_state_t;

    drv_state_t st_d, st_q;
    logic [W-1:0] wr_sel;

    always_comb begin
        st_d   = st_q;
        wr_sel = (strobe_i && wr_valid_i) ? dir_i : '0;
        for (int i = 0; i < W; i++) begin
            if (wr_sel[i]) begin
                st_d.val[i]    = wr_bits_i[i];
                st_d.loaded[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_out_o = st_q.val;
    assign pin_oe_o  = dir_i & oe_i & st_q.loaded;

    // R3
    out_change_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_i && wr_valid_i) |=> $stable(pin_out_o));

    // R4
    input_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (((pin_out_o ^ $past(pin_out_o)) & ~$past(dir_i)) == '0));
endmodule

// File: rtl/gpio_slot_evt.sv
module gpio_slot_evt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_i,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mask_i,
    output logic         flag_o
);
    typedef struct packed {
        logic [W-1:0] last;
        logic         pend;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic [W-1:0] hits;
    logic         hit_any;

    always_comb begin
        st_d    = st_q;
        hits    = (sync_i ^ st_q.last) & ~dir_i & mask_i;
        hit_any = |hits;
        st_d.last = sync_i;
        if (strobe_i) st_d.pend = 1'b0;
        else          st_d.pend = st_q.pend | hit_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.pend | hit_any;
endmodule

// File: rtl/gpio_slot_ctl.sv
module gpio_slot_ctl
    import gpio_slot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_strobe,
    input  logic [SLOT_W-1:0] out_slot,
    input  logic              out_valid,
    output logic [SLOT_W-1:0] in_slot,
    input  logic [NPINS-1:0]  cfg_dir,
    input  logic [NPINS-1:0]  cfg_oe,
    input  logic [NPINS-1:0]  cfg_mask,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] status;
    logic             irq_flag;
    logic [PIN_LSB-1:0] unused_low;

    assign unused_low = out_slot[PIN_LSB-1:0];

    gpio_slot_sync #(.W(NPINS), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (pin_sync)
    );

    gpio_slot_drv #(.W(NPINS)) u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_i   (frame_strobe),
        .wr_valid_i (out_valid),
        .wr_bits_i  (out_slot[SLOT_W-1:PIN_LSB]),
        .dir_i      (cfg_dir),
        .oe_i       (cfg_oe),
        .pin_out_o  (pin_out),
        .pin_oe_o   (pin_oe)
    );

    gpio_slot_evt #(.W(NPINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (frame_strobe),
        .sync_i   (pin_sync),
        .dir_i    (cfg_dir),
        .mask_i   (cfg_mask),
        .flag_o   (irq_flag)
    );

    always_comb begin
        st_d   = st_q;
        status = (cfg_dir & pin_out) | (~cfg_dir & pin_sync);
        if (frame_strobe) begin
            st_d.slot = {status, {VEND_W{1'b0}}, irq_flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_slot = st_q.slot;

    // R10
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> $stable(in_slot));

    // R2
    vendor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_slot[PIN_LSB-1:1] == '0);

    // R7
    same_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> ((in_slot[SLOT_W-1:PIN_LSB] & $past(cfg_dir)) ==
                          ($past(pin_out) & $past(cfg_dir))));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_slot[IRQ_BIT]) |-> $past(frame_strobe));
endmodule

// File: tb/gpio_slot_ctl_bench.sv
module gpio_slot_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic [19:0] out_slot = '0;
    logic        out_valid = 1'b0;
    logic [19:0] in_slot;
    logic [15:0] cfg_dir = '0, cfg_oe = '0, cfg_mask = '0, pin_in = '0;
    logic [15:0] pin_out, pin_oe;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_out = '0, m_loaded = '0;
    logic        m_pend = 1'b0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    gpio_slot_ctl u_gpio_slot_ctl (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .out_slot(out_slot), .out_valid(out_valid), .in_slot(in_slot),
        .cfg_dir(cfg_dir), .cfg_oe(cfg_oe), .cfg_mask(cfg_mask),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input logic [19:0] act, input logic [19:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] d, input logic [15:0] o, input logic [15:0] m);
        @(negedge clk);
        cfg_dir = d; cfg_oe = o; cfg_mask = m;
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        m_pend = m_pend | (|((v ^ pin_in) & ~cfg_dir & cfg_mask));
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_frame(input logic [19:0] s, input logic v, input string tag);
        logic [19:0] exp_slot;
        @(negedge clk);
        out_slot = s; out_valid = v; frame_strobe = 1'b1;
        exp_slot = {(cfg_dir & m_out) | (~cfg_dir & pin_in), 3'b000, m_pend};
        @(negedge clk);
        frame_strobe = 1'b0; out_valid = 1'b0;
        if (v) begin
            m_out    = (m_out & ~cfg_dir) | (s[19:4] & cfg_dir);
            m_loaded = m_loaded | cfg_dir;
        end
        m_pend = 1'b0;
        chk(in_slot, exp_slot, {tag, " R6 R7 slot"});
        chk({4'h0, pin_out}, {4'h0, m_out}, {tag, " R3 R4 pin_out"});
        chk({4'h0, pin_oe}, {4'h0, cfg_dir & cfg_oe & m_loaded}, {tag, " R5 pin_oe"});
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_slot, '0, "R1 in_slot");
        chk({4'h0, pin_out}, '0, "R1 pin_out");
        chk({4'h0, pin_oe}, '0, "R1 pin_oe");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({4'h0, pin_oe}, '0, "R1 pin_oe after release");

        // R5: enables set but nothing loaded yet
        set_cfg(16'hFFFF, 16'hFFFF, 16'h0000);
        chk({4'h0, pin_oe}, '0, "R5 no load no enable");
        do_frame(20'h00000, 1'b0, "R3 invalid");
        chk({4'h0, pin_oe}, '0, "R5 invalid write no enable");

        // R3/R2: walking ones with vendor and flag bits set outbound
        for (int i = 0; i < 16; i++) begin
            do_frame({16'h0001 << i, 4'hF}, 1'b1, "R2 R3 walk");
        end
        chk(in_slot, {16'h4000, 4'h0}, "R7 status before last write");
        do_frame({16'hA5C3, 4'hF}, 1'b0, "R3 valid low ignored");
        do_frame({16'hFFFF, 4'h0}, 1'b1, "R3 all ones");

        // R4: lower half input, writes there ignored
        set_cfg(16'hFF00, 16'hFFFF, 16'h0000);
        do_frame({16'h0000, 4'h0}, 1'b1, "R4 input bits ignored");
        chk({4'h0, pin_out}, {4'h0, 16'h00FF}, "R4 input pins hold");

        // R8/R9: unmasked input change
        set_cfg(16'hFF00, 16'hFF00, 16'h00FF);
        set_pins(16'h0004);
        do_frame(20'h0, 1'b0, "R8 change flagged");
        chk({19'h0, in_slot[0]}, 20'h1, "R8 flag bit");
        do_frame(20'h0, 1'b0, "R9 flag cleared");
        chk({19'h0, in_slot[0]}, 20'h0, "R9 flag bit");
        // R8: masked-off pin, output pin
        set_cfg(16'hFF00, 16'hFF00, 16'h00FB);
        set_pins(16'h0000);
        do_frame(20'h0, 1'b0, "R8 masked change");
        chk({19'h0, in_slot[0]}, 20'h0, "R8 masked no flag");
        set_pins(16'h0100);
        do_frame(20'h0, 1'b0, "R8 output-pin change");
        chk({19'h0, in_slot[0]}, 20'h0, "R8 output pin no flag");

        // R10: slot holds between strobes despite pin change
        held = in_slot;
        set_cfg(16'h0000, 16'h0000, 16'hFFFF);
        set_pins(16'h1234);
        chk(in_slot, held, "R10 hold");
        do_frame(20'h0, 1'b0, "R10 refresh");

        // Sweep: pseudo-random configurations and patterns
        for (int k = 0; k < 300; k++) begin
            logic [15:0] d, o, m, p;
            logic [19:0] s;
            d = 16'($urandom); o = 16'($urandom); m = 16'($urandom);
            p = 16'($urandom); s = 20'($urandom);
            set_cfg(d, o, m);
            if (k % 3 != 0) set_pins(p);
            do_frame(s, (k % 5) != 0, "sweep R3 R4 R5 R6 R7 R8 R9");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule